// File: doc/BRIEF.md
# Grouped Event-Counter Performance Monitor

This block counts hardware events for profiling. It holds a configurable number of 32-bit counters, arranged in equal-sized groups. Each counter has a selector that picks one line of a shared event input bus. A counter advances by one on every clock edge where its selected line is high, but only if three switches are all on: the global switch, the switch of the counter's group, and the counter's own switch.

Software reaches everything through a small 32-bit register bus. Per-counter switches and per-counter interrupt enables are changed through separate set and clear words. Writing a 1 to a bit changes that counter's state, and writing a 0 leaves it alone. Each counter has a sticky overflow flag, which software clears by writing a 1 to it. A single level interrupt output goes high while any flagged counter also has its interrupt enabled.

Top module: `perfmon_grouped`

## Requirements
- R1: After a synchronous reset, the following are all zero: every counter value, every event selector, every switch, every interrupt enable, every overflow flag, read data and `irq`.
- R2: The word at 0x004 reads back the configuration. The group count is in bits 31:24 and the total counter count is in bits 7:0. Each group control word (0x100 + 4·g) reports its per-group counter count in bits 27:24.
- R3: Counter n belongs to group n / CNT_PER_GROUP. On a clock edge it increments by exactly one when all of the following hold, and otherwise it holds its value:
  - bit 0 of the global control word (0x000) is 1;
  - bit 11 of its group control word is 1;
  - its own enable is 1;
  - its selected event line is high.
- R4: The selector word of counter n (0x800 + 4·n) holds the index of the event line the counter watches, and it reads back what was written.
- R5: Counter n's enable sits in word n/32, bit n%32. Writing 1s at 0x200 + 4·w sets those enables, and writing 1s at 0x280 + 4·w clears them. Zero bits leave the state unchanged. Reading either address returns the current enables.
- R6: Interrupt enables follow the same scheme, with set at 0x300 + 4·w and clear at 0x380 + 4·w.
- R7: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag (0x400 + 4·w, same bit layout as R5) on that same edge. The flag stays set until a 1 is written to its bit, and a 0 write leaves it set.
- R8: Writing 1 to bit 1 of the global control word zeroes every counter on that edge, even if an event would have made a counter increment. This write leaves switches and overflow flags unchanged. Bit 1 always reads as 0.
- R9: `irq` is registered. It is high one cycle after any counter has both its overflow flag and its interrupt enable set, and low one cycle after no counter does.
- R10: The value word of counter n (0xC00 + 4·n) reads the live count and may be written to preload it. A preload takes priority over an increment on the same edge.
- R11: A read returns data, with `bus_rvalid` high, in the cycle after `bus_re`. Unmapped addresses, and indices past the configured groups or counters, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_re` |
| bus_rvalid | output | 1 | Read data valid |
| event_in | input | NUM_EVENTS | Event lines, sampled on each clock edge |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the bus asks for at most one access per cycle and uses word-aligned addresses. They also assume that counter values change only through increments, preloads and the reset bit. The stimulus drives all inputs on falling edges, issues a single read or write per bus slot, and uses only aligned addresses. Wrap cases are reached by preloading counters near the top of their range rather than by counting there. The bench drives event lines as bursts of known length, so each expected count follows directly from the number of rising edges that see the line high.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  localparam logic [11:0] A_GCTRL = 12'h000;
  localparam logic [11:0] A_CFG   = 12'h004;
  localparam logic [11:0] A_ENSET = 12'h200;
  localparam logic [11:0] A_ENCLR = 12'h280;
  localparam logic [11:0] A_OVF   = 12'h400;

  localparam int GEN_BIT  = 0;
  localparam int CRST_BIT = 1;
  localparam int GEN_GRP_BIT = 11;

  typedef enum logic [3:0] {
    RG_NONE, RG_GCTRL, RG_CFG, RG_GRP, RG_ENSET, RG_ENCLR,
    RG_IESET, RG_IECLR, RG_OVF, RG_EVT, RG_CNT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;
  } reg_hit_t;

  // Address regions: 0x000 globals, 0x100 groups, 0x200/0x280 enable set/clear,
  // 0x300/0x380 irq-enable set/clear, 0x400 overflow, 0x800 selectors, 0xC00 values.
  function automatic reg_hit_t pm_decode(input logic [11:0] a);
    reg_hit_t h;
    h.kind = RG_NONE;
    h.idx  = a[9:2];
    if (a[1:0] == 2'b00) begin
      unique case (a[11:10])
        2'b00: begin
          unique case (a[9:8])
            2'b00: begin
              if (a[7:2] == 6'd0)      h.kind = RG_GCTRL;
              else if (a[7:2] == 6'd1) h.kind = RG_CFG;
            end
            2'b01: begin
              h.kind = RG_GRP;
              h.idx  = {2'b00, a[7:2]};
            end
            2'b10: begin
              h.kind = a[7] ? RG_ENCLR : RG_ENSET;
              h.idx  = {3'b000, a[6:2]};
            end
            default: begin
              h.kind = a[7] ? RG_IECLR : RG_IESET;
              h.idx  = {3'b000, a[6:2]};
            end
          endcase
        end
        2'b01: begin
          if (a[9:7] == 3'b000) begin
            h.kind = RG_OVF;
            h.idx  = {3'b000, a[6:2]};
          end
        end
        2'b10:   h.kind = RG_EVT;
        default: h.kind = RG_CNT;
      endcase
    end
    return h;
  endfunction

endpackage

// File: rtl/perfmon_bitvec.sv
module perfmon_bitvec #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] q
);
  // Set wins over clear so a hardware event is never lost to a racing clear.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int NUM_EVENTS = 8,
  parameter int SEL_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  count_ok,
  input  logic [NUM_EVENTS-1:0] events,
  input  logic                  sel_we,
  input  logic                  val_we,
  input  logic                  clr_all,
  input  logic [31:0]           wdata,
  output logic [SEL_W-1:0]      sel,
  output logic [31:0]           val,
  output logic                  wrap
);
  localparam int PAD = 1 << SEL_W;

  logic [PAD-1:0] ev_pad;
  logic           evt_hit;

  always_comb begin
    ev_pad = '0;
    ev_pad[NUM_EVENTS-1:0] = events;
  end

  assign evt_hit = count_ok && ev_pad[sel];
  assign wrap    = evt_hit && !clr_all && !val_we && (&val);

  always_ff @(posedge clk) begin
    if (rst)         sel <= '0;
    else if (sel_we) sel <= wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          val <= '0;
    else if (clr_all) val <= '0;
    else if (val_we)  val <= wdata;
    else if (evt_hit) val <= val + 32'd1;
  end
endmodule

// File: rtl/perfmon_irq.sv
module perfmon_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & enables);
  end
endmodule

// File: rtl/perfmon_grouped.sv
module perfmon_grouped #(
  parameter int NUM_GROUPS    = 2,
  parameter int CNT_PER_GROUP = 4,
  parameter int NUM_EVENTS    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic                  bus_re,
  input  logic [11:0]           bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_rvalid,
  input  logic [NUM_EVENTS-1:0] event_in,
  output logic                  irq
);
  import perfmon_pkg::*;

  localparam int NCNT  = NUM_GROUPS * CNT_PER_GROUP;
  localparam int SEL_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;
  localparam logic [7:0] NG_F  = 8'(NUM_GROUPS);
  localparam logic [7:0] NC_F  = 8'(NCNT);
  localparam logic [3:0] CPG_F = 4'(CNT_PER_GROUP);

  reg_hit_t hit;
  assign hit = pm_decode(bus_addr);

  logic                  gen_q;
  logic                  clr_all;
  logic [NUM_GROUPS-1:0] grp_en_q;
  logic [NCNT-1:0]       en_q, ien_q, ovf_q;
  logic [NCNT-1:0]       en_set, en_clr, ie_set, ie_clr, ovf_clr;
  logic [NCNT-1:0]       wrap, count_ok;
  logic [31:0]           cnt_val [NCNT];
  logic [SEL_W-1:0]      cnt_sel [NCNT];
  logic [NCNT*32-1:0]    cnt_flat;
  logic [31:0]           rd_nxt;

  // Global control: bit 0 latches, bit 1 is a one-shot counter clear.
  always_ff @(posedge clk) begin
    if (rst)                              gen_q <= 1'b0;
    else if (bus_we && hit.kind == RG_GCTRL) gen_q <= bus_wdata[GEN_BIT];
  end
  assign clr_all = bus_we && (hit.kind == RG_GCTRL) && bus_wdata[CRST_BIT];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst)
        grp_en_q[g] <= 1'b0;
      else if (bus_we && hit.kind == RG_GRP && hit.idx == 8'(g))
        grp_en_q[g] <= bus_wdata[GEN_GRP_BIT];
    end
  end

  // Per-counter write masks from packed 32-bit words.
  always_comb begin
    en_set  = '0;
    en_clr  = '0;
    ie_set  = '0;
    ie_clr  = '0;
    ovf_clr = '0;
    for (int n = 0; n < NCNT; n++) begin
      if (bus_we && hit.idx == 8'(n / 32)) begin
        en_set[n]  = (hit.kind == RG_ENSET) && bus_wdata[n % 32];
        en_clr[n]  = (hit.kind == RG_ENCLR) && bus_wdata[n % 32];
        ie_set[n]  = (hit.kind == RG_IESET) && bus_wdata[n % 32];
        ie_clr[n]  = (hit.kind == RG_IECLR) && bus_wdata[n % 32];
        ovf_clr[n] = (hit.kind == RG_OVF)   && bus_wdata[n % 32];
      end
    end
  end

  perfmon_bitvec #(.N(NCNT)) u_en (
    .clk(clk), .rst(rst), .set_mask(en_set), .clr_mask(en_clr), .q(en_q));
  perfmon_bitvec #(.N(NCNT)) u_ien (
    .clk(clk), .rst(rst), .set_mask(ie_set), .clr_mask(ie_clr), .q(ien_q));
  perfmon_bitvec #(.N(NCNT)) u_ovf (
    .clk(clk), .rst(rst), .set_mask(wrap), .clr_mask(ovf_clr), .q(ovf_q));

  for (genvar n = 0; n < NCNT; n++) begin : g_cnt
    assign count_ok[n] = gen_q && grp_en_q[n / CNT_PER_GROUP] && en_q[n];

    perfmon_counter #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .count_ok(count_ok[n]),
      .events  (event_in),
      .sel_we  (bus_we && hit.kind == RG_EVT && hit.idx == 8'(n)),
      .val_we  (bus_we && hit.kind == RG_CNT && hit.idx == 8'(n)),
      .clr_all (clr_all),
      .wdata   (bus_wdata),
      .sel     (cnt_sel[n]),
      .val     (cnt_val[n]),
      .wrap    (wrap[n])
    );

    assign cnt_flat[n*32 +: 32] = cnt_val[n];
  end

  perfmon_irq #(.N(NCNT)) u_irq (
    .clk(clk), .rst(rst), .flags(ovf_q), .enables(ien_q), .irq(irq));

  // Read mux, registered one cycle.
  always_comb begin
    rd_nxt = '0;
    unique case (hit.kind)
      RG_GCTRL: rd_nxt[GEN_BIT] = gen_q;
      RG_CFG:   rd_nxt = {NG_F, 16'h0000, NC_F};
      RG_GRP: begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
          if (hit.idx == 8'(g)) begin
            rd_nxt[27:24]       = CPG_F;
            rd_nxt[GEN_GRP_BIT] = grp_en_q[g];
          end
        end
      end
      RG_ENSET, RG_ENCLR, RG_IESET, RG_IECLR, RG_OVF: begin
        for (int n = 0; n < NCNT; n++) begin
          if (hit.idx == 8'(n / 32)) begin
            if (hit.kind == RG_OVF)                             rd_nxt[n % 32] = ovf_q[n];
            else if (hit.kind == RG_ENSET || hit.kind == RG_ENCLR) rd_nxt[n % 32] = en_q[n];
            else                                                rd_nxt[n % 32] = ien_q[n];
          end
        end
      end
      RG_EVT: begin
        for (int n = 0; n < NCNT; n++)
          if (hit.idx == 8'(n)) rd_nxt[SEL_W-1:0] = cnt_sel[n];
      end
      RG_CNT: begin
        for (int n = 0; n < NCNT; n++)
          if (hit.idx == 8'(n)) rd_nxt = cnt_val[n];
      end
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) bus_rdata <= rd_nxt;
    end
  end
endmodule

// File: rtl/perfmon_checker.sv
module perfmon_checker #(
  parameter int NCNT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic             bus_re,
  input logic [11:0]      bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             bus_rvalid,
  input logic             irq,
  input logic             gen_q,
  input logic [NCNT-1:0]  en_q,
  input logic [NCNT-1:0]  ien_q,
  input logic [NCNT-1:0]  ovf_q,
  input logic [NCNT*32-1:0] cnt_flat
);
  localparam int W0 = (NCNT < 32) ? NCNT : 32;

  logic wr_gctrl, wr_enset, wr_enclr, wr_ovf;
  assign wr_gctrl = bus_we && bus_addr == 12'h000;
  assign wr_enset = bus_we && bus_addr == 12'h200;
  assign wr_enclr = bus_we && bus_addr == 12'h280;
  assign wr_ovf   = bus_we && bus_addr[11:7] == 5'b01000;

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> bus_rvalid);

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_gctrl && bus_wdata[1]) |=> (cnt_flat == '0));

  assert_hold_global_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!gen_q && !bus_we) |=> $stable(cnt_flat));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_ovf |=> ((~ovf_q & $past(ovf_q)) == '0));

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (|(ovf_q & ien_q)) |=> irq);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(ovf_q & ien_q)) |=> !irq);

  assert_enset_R5: assert property (@(posedge clk) disable iff (rst)
    wr_enset |=> ((en_q[W0-1:0] & $past(bus_wdata[W0-1:0])) == $past(bus_wdata[W0-1:0])));

  assert_enclr_R5: assert property (@(posedge clk) disable iff (rst)
    wr_enclr |=> ((en_q[W0-1:0] & $past(bus_wdata[W0-1:0])) == '0));
endmodule

bind perfmon_grouped perfmon_checker #(.NCNT(NCNT)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .irq(irq), .gen_q(gen_q),
  .en_q(en_q), .ien_q(ien_q), .ovf_q(ovf_q), .cnt_flat(cnt_flat));

// File: tb/sim_perfmon_grouped.sv
module sim_perfmon_grouped;
  localparam int CLK_PERIOD = 10;
  localparam int NEV = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_we = 1'b0, bus_re = 1'b0;
  logic [11:0]    bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           bus_rvalid;
  logic [NEV-1:0] event_in = '0;
  logic           irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  perfmon_grouped #(.NUM_GROUPS(2), .CNT_PER_GROUP(4), .NUM_EVENTS(NEV)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .event_in(event_in), .irq(irq));

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // Driver: issue read, push expected item to scoreboard.
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    @(negedge clk);
    event_in[idx] = 1'b1;
    repeat (n) @(negedge clk);
    event_in[idx] = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", t, act, e);
    end
  endtask

  // Monitor: pop and compare as read data emerges.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11 unexpected rvalid act=%h exp=none", bus_rdata);
      end else begin
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({31'd0, irq}, 32'd0, "R1 irq after reset");
    rd(12'h000, 32'h0, "R1 gctrl reset");
    rd(12'h200, 32'h0, "R1 enables reset");
    rd(12'hC00, 32'h0, "R1 counter reset");
    rd(12'h400, 32'h0, "R1 overflow reset");
    rd(12'h004, 32'h0200_0008, "R2 config");
    rd(12'h104, 32'h0400_0000, "R2 group1 size");

    // R4 selectors
    wr(12'h800, 32'd3);
    wr(12'h804, 32'd5);
    wr(12'h810, 32'd3);
    rd(12'h800, 32'd3, "R4 sel0 readback");
    rd(12'h804, 32'd5, "R4 sel1 readback");

    // R5 enable set/clear
    wr(12'h200, 32'h13);
    rd(12'h200, 32'h13, "R5 enset read");
    rd(12'h280, 32'h13, "R5 enclr read");
    wr(12'h280, 32'h02);
    rd(12'h200, 32'h11, "R5 clear bit1");
    wr(12'h200, 32'h00);
    rd(12'h280, 32'h11, "R5 zero write no effect");

    // R3 gating levels
    wr(12'h000, 32'h1);
    pulse(3, 5);
    rd(12'hC00, 32'd0, "R3 group off holds");
    wr(12'h100, 32'h800);
    rd(12'h100, 32'h0400_0800, "R2 group0 word");
    pulse(3, 5);
    pulse(5, 3);
    rd(12'hC00, 32'd5, "R3 cnt0 counts");
    rd(12'hC10, 32'd0, "R3 cnt4 group1 off");
    rd(12'hC04, 32'd0, "R5 cnt1 disabled");
    wr(12'h104, 32'h800);
    pulse(3, 3);
    rd(12'hC00, 32'd8, "R3 cnt0 after more");
    rd(12'hC10, 32'd3, "R3 cnt4 counts");
    wr(12'h000, 32'h0);
    pulse(3, 4);
    rd(12'hC00, 32'd8, "R3 global off holds");

    // R10 preload, R7/R9 overflow and interrupt
    wr(12'hC00, 32'hFFFF_FFFE);
    rd(12'hC00, 32'hFFFF_FFFE, "R10 preload readback");
    wr(12'h300, 32'h1);
    rd(12'h300, 32'h1, "R6 ieset read");
    rd(12'h380, 32'h1, "R6 ieclr read");
    wr(12'h000, 32'h1);
    pulse(3, 2);
    rd(12'h400, 32'h1, "R7 overflow set on wrap");
    rd(12'hC00, 32'd0, "R7 counter wrapped");
    repeat (2) @(negedge clk);
    chk({31'd0, irq}, 32'd1, "R9 irq high");
    wr(12'h400, 32'h0);
    rd(12'h400, 32'h1, "R7 zero write keeps flag");
    chk({31'd0, irq}, 32'd1, "R9 irq stays");
    wr(12'h400, 32'h1);
    rd(12'h400, 32'h0, "R7 w1c clears");
    chk({31'd0, irq}, 32'd0, "R9 irq low after clear");
    wr(12'h380, 32'h1);
    rd(12'h300, 32'h0, "R6 ie cleared");

    // Overflow with interrupt disabled
    wr(12'hC10, 32'hFFFF_FFFF);
    pulse(3, 1);
    rd(12'h400, 32'h10, "R7 cnt4 overflow");
    repeat (2) @(negedge clk);
    chk({31'd0, irq}, 32'd0, "R9 masked overflow no irq");

    // R8 counter clear beats increment
    @(negedge clk);
    event_in[3] = 1'b1;
    wr(12'h000, 32'h3);
    event_in[3] = 1'b0;
    rd(12'h000, 32'h1, "R8 bit1 reads zero");
    rd(12'hC00, 32'd0, "R8 cnt0 cleared");
    rd(12'hC10, 32'd0, "R8 cnt4 cleared");
    rd(12'h200, 32'h11, "R8 enables kept");
    rd(12'h400, 32'h10, "R8 overflow kept");

    // R4 distinct selector
    wr(12'h200, 32'h02);
    pulse(5, 2);
    rd(12'hC04, 32'd2, "R4 cnt1 on line5");
    rd(12'hC00, 32'd0, "R4 cnt0 ignores line5");

    // R11 unmapped
    rd(12'h0F0, 32'h0, "R11 unmapped");
    rd(12'h404, 32'h0, "R11 ovf word1");
    rd(12'h850, 32'h0, "R11 sel beyond count");
    rd(12'h114, 32'h0, "R11 group beyond count");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 missing reads act=%0d exp=0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule